// File: doc/BRIEF.md
# Banked Data Memory Address Mapper

This block sits between an 8-bit core's operand decoder and its data memory. It turns a 7-bit file address into a 9-bit physical data-memory address. A direct access takes its upper two address bits from a pair of bank-select bits. When the file address is zero, the access goes through a pointer instead: the 8-bit pointer register supplies the low bits and a single indirect bank bit supplies the top bit.

After it picks the address, the mapper decides which region the address falls in. The lowest 32 offsets of each bank hold special-function registers. Offsets 70h–7Fh of every bank share the same storage, so the mapper folds them back onto 70h–7Fh. Some general-purpose locations are not built in a given configuration; the mapper flags these, so the memory returns zero on a read and drops a write.

A pointer access whose pointer lands on offset zero of any bank refers back to the pointer pseudo-register itself. Such an access reads as zero and writes nothing. All outputs are registered and appear one clock after the inputs. A change of bank bits therefore applies to the next access, with no extra delay.

Top module: `bank_addr_mapper`

## Requirements
- R1: With a file address other than 00h and an offset outside 70h–7Fh, phys_addr equals {bank_sel[1:0], file_addr[6:0]} (bank 0 = 000h–07Fh, bank 1 = 080h–0FFh, bank 2 = 100h–17Fh, bank 3 = 180h–1FFh). A change of bank_sel is reflected on the very next access.
- R2: With file_addr = 00h, the effective address is {ind_bank, ptr[7:0]} and bank_sel has no effect on it.
- R3: Any effective address whose low 7 bits lie in 70h–7Fh, in any bank, is output as 070h–07Fh, with bits 8:7 of phys_addr zero.
- R4: sfr_sel is 1 exactly when the low 7 bits of the effective address are below 20h. Writes there are never blocked unless R6 applies.
- R5: A read (rd_en = 1) through the pointer with ptr[6:0] = 0 sets rd_zero.
- R6: A write (wr_en = 1) through the pointer with ptr[6:0] = 0 sets wr_block.
- R7: General-purpose offsets above a per-bank limit are absent. The default limits are 7Fh, 7Fh, 4Fh and 1Fh for banks 0 to 3, so 150h–16Fh and 1A0h–1EFh are absent. A read of an absent offset sets rd_zero and a write sets wr_block. Offsets at or below the limit, and the shared 70h–7Fh window, are never absent.
- R8: Outputs are updated on the rising clock edge after the inputs. A synchronous active-high reset drives phys_addr, rd_zero, wr_block and sfr_sel to 0.
- R9: rd_zero is never 1 unless rd_en was 1, and wr_block is never 1 unless wr_en was 1, on the access it belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| file_addr | input | 7 | File address from the instruction |
| bank_sel | input | 2 | Bank select for direct access |
| ind_bank | input | 1 | Bank bit for pointer access |
| ptr | input | 8 | Pointer register value |
| rd_en | input | 1 | Read strobe for this access |
| wr_en | input | 1 | Write strobe for this access |
| phys_addr | output | 9 | Physical data-memory address |
| rd_zero | output | 1 | Read must return 00h |
| wr_block | output | 1 | Write must be dropped |
| sfr_sel | output | 1 | Address is in the special-function region |

## Verification
The assertions compare each registered output with the inputs of the previous clock. They only do so once one full cycle has passed since reset, so they rely on the inputs being stable across each rising edge. The bench changes every input on the falling edge and reads the outputs on the next falling edge, so each access sits still for a full rising edge. The properties also assume the pointer is one bit wider than the file address. The bench's pointer values cover all three settings of the pointer's top bit and the indirect bank bit that matter: bank 0, bank 1 through bit 7, and banks 2–3 through ind_bank.

// File: rtl/bank_addr_pkg.sv
package bank_addr_pkg;
  // kind of path that produced an effective address
  typedef enum logic {
    PATH_DIRECT = 1'b0,
    PATH_PTR    = 1'b1
  } path_e;

  // per-access result flags, registered together at the top
  typedef struct packed {
    logic rd_zero;
    logic wr_block;
    logic sfr_sel;
  } acc_flags_t;
endpackage

// File: rtl/bank_addr_select.sv
module bank_addr_select #(
  parameter int OFS_W  = 7,
  parameter int BANK_W = 2,
  parameter int PTR_W  = 8,
  localparam int PHYS_W = BANK_W + OFS_W
) (
  input  logic [OFS_W-1:0]   file_addr,
  input  logic [BANK_W-1:0]  bank_sel,
  input  logic               ind_bank,
  input  logic [PTR_W-1:0]   ptr,
  output logic [PHYS_W-1:0]  eff_addr,
  output bank_addr_pkg::path_e path
);
  import bank_addr_pkg::*;

  localparam int IND_PAD = PHYS_W - PTR_W;

  logic [PHYS_W-1:0] direct_addr;
  logic [PHYS_W-1:0] ptr_addr;

  assign direct_addr = {bank_sel, file_addr};

  generate
    if (IND_PAD == 1) begin : g_ind_exact
      assign ptr_addr = {ind_bank, ptr};
    end else begin : g_ind_pad
      assign ptr_addr = {{(IND_PAD - 1){1'b0}}, ind_bank, ptr[PTR_W-1:0]};
    end
  endgenerate

  always_comb begin
    if (file_addr == '0) begin
      path     = PATH_PTR;
      eff_addr = ptr_addr;
    end else begin
      path     = PATH_DIRECT;
      eff_addr = direct_addr;
    end
  end
endmodule

// File: rtl/bank_region_decode.sv
module bank_region_decode #(
  parameter int OFS_W      = 7,
  parameter int BANK_W     = 2,
  parameter int SFR_SPAN   = 32,
  parameter int COMMON_LEN = 16,
  parameter logic [(1<<BANK_W)*OFS_W-1:0] GPR_TOP = {7'h1F, 7'h4F, 7'h7F, 7'h7F},
  localparam int PHYS_W = BANK_W + OFS_W,
  localparam int NBANK  = 1 << BANK_W
) (
  input  logic [PHYS_W-1:0] eff_addr,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              sfr_hit,
  output logic              common_hit,
  output logic              gpr_absent
);
  localparam logic [OFS_W-1:0] SFR_END   = OFS_W'(SFR_SPAN);
  localparam logic [OFS_W-1:0] COMMON_LO = OFS_W'((1 << OFS_W) - COMMON_LEN);

  logic [OFS_W-1:0]  offset;
  logic [BANK_W-1:0] bank;
  logic [NBANK-1:0]  bank_absent;

  assign offset     = eff_addr[OFS_W-1:0];
  assign bank       = eff_addr[PHYS_W-1:OFS_W];
  assign sfr_hit    = offset < SFR_END;
  assign common_hit = offset >= COMMON_LO;

  genvar b;
  generate
    for (b = 0; b < NBANK; b++) begin : g_bank
      localparam logic [OFS_W-1:0] TOP = GPR_TOP[b*OFS_W +: OFS_W];
      assign bank_absent[b] = (bank == BANK_W'(b)) && !sfr_hit && !common_hit
                              && (offset > TOP);
    end
  endgenerate

  assign gpr_absent = |bank_absent;
  assign phys_addr  = common_hit ? {{BANK_W{1'b0}}, offset} : eff_addr;
endmodule

// File: rtl/bank_addr_mapper.sv
module bank_addr_mapper #(
  parameter int OFS_W      = 7,
  parameter int BANK_W     = 2,
  parameter int PTR_W      = 8,
  parameter int SFR_SPAN   = 32,
  parameter int COMMON_LEN = 16,
  parameter logic [(1<<BANK_W)*OFS_W-1:0] GPR_TOP = {7'h1F, 7'h4F, 7'h7F, 7'h7F},
  localparam int PHYS_W = BANK_W + OFS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OFS_W-1:0]   file_addr,
  input  logic [BANK_W-1:0]  bank_sel,
  input  logic               ind_bank,
  input  logic [PTR_W-1:0]   ptr,
  input  logic               rd_en,
  input  logic               wr_en,
  output logic [PHYS_W-1:0]  phys_addr,
  output logic               rd_zero,
  output logic               wr_block,
  output logic               sfr_sel
);
  import bank_addr_pkg::*;

  localparam logic [OFS_W-1:0] SFR_END   = OFS_W'(SFR_SPAN);
  localparam logic [OFS_W-1:0] COMMON_LO = OFS_W'((1 << OFS_W) - COMMON_LEN);

  logic [PHYS_W-1:0] eff_addr;
  path_e             path;
  logic [PHYS_W-1:0] mapped_addr;
  logic              sfr_hit;
  logic              common_hit;
  logic              gpr_absent;
  logic              self_ref;
  logic              suppress;
  acc_flags_t        flags_d;
  acc_flags_t        flags_q;
  logic [PHYS_W-1:0] addr_q;

  bank_addr_select #(
    .OFS_W (OFS_W),
    .BANK_W(BANK_W),
    .PTR_W (PTR_W)
  ) u_select (
    .file_addr(file_addr),
    .bank_sel (bank_sel),
    .ind_bank (ind_bank),
    .ptr      (ptr),
    .eff_addr (eff_addr),
    .path     (path)
  );

  bank_region_decode #(
    .OFS_W     (OFS_W),
    .BANK_W    (BANK_W),
    .SFR_SPAN  (SFR_SPAN),
    .COMMON_LEN(COMMON_LEN),
    .GPR_TOP   (GPR_TOP)
  ) u_region (
    .eff_addr  (eff_addr),
    .phys_addr (mapped_addr),
    .sfr_hit   (sfr_hit),
    .common_hit(common_hit),
    .gpr_absent(gpr_absent)
  );

  // pointer that lands on offset 0 of any bank names the pseudo-register again
  assign self_ref = (path == PATH_PTR) && (eff_addr[OFS_W-1:0] == '0);
  assign suppress = self_ref || gpr_absent;

  always_comb begin
    flags_d.rd_zero  = rd_en && suppress;
    flags_d.wr_block = wr_en && suppress;
    flags_d.sfr_sel  = sfr_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      flags_q <= '0;
    end else begin
      addr_q  <= mapped_addr;
      flags_q <= flags_d;
    end
  end

  assign phys_addr = addr_q;
  assign rd_zero   = flags_q.rd_zero;
  assign wr_block  = flags_q.wr_block;
  assign sfr_sel   = flags_q.sfr_sel;

  // one full cycle out of reset before looking back
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R1
  direct_path_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(file_addr) >= SFR_END && $past(file_addr) < COMMON_LO)
      |-> (phys_addr == {$past(bank_sel), $past(file_addr)}));

  // R3
  common_fold_chk: assert property (@(posedge clk) disable iff (rst)
    (phys_addr[OFS_W-1:0] >= COMMON_LO) |-> (phys_addr[PHYS_W-1:OFS_W] == '0));

  // R6
  sfr_block_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_block && sfr_sel) |-> (phys_addr[OFS_W-1:0] == '0));

  // R9
  rd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rd_en)) |-> !rd_zero);

  // R9
  wr_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(wr_en)) |-> !wr_block);

  // R4
  sfr_range_chk: assert property (@(posedge clk) disable iff (rst)
    sfr_sel |-> (phys_addr[OFS_W-1:0] < SFR_END));
endmodule

// File: tb/tb_bank_addr_mapper.sv
module tb_bank_addr_mapper;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] file_addr = '0;
  logic [1:0] bank_sel = '0;
  logic       ind_bank = 1'b0;
  logic [7:0] ptr = '0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] phys_addr;
  logic       rd_zero;
  logic       wr_block;
  logic       sfr_sel;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  bank_addr_mapper dut (
    .clk(clk), .rst(rst), .file_addr(file_addr), .bank_sel(bank_sel),
    .ind_bank(ind_bank), .ptr(ptr), .rd_en(rd_en), .wr_en(wr_en),
    .phys_addr(phys_addr), .rd_zero(rd_zero), .wr_block(wr_block),
    .sfr_sel(sfr_sel)
  );

  // {file_addr, bank_sel, ind_bank, ptr, rd, wr, exp_phys, exp_rz, exp_wb, exp_sfr}
  localparam int NV = 23;
  localparam logic [31:0] VEC [NV] = '{
    {7'h25, 2'd0, 1'b0, 8'h00, 1'b1, 1'b0, 9'h025, 1'b0, 1'b0, 1'b0},
    {7'h45, 2'd1, 1'b0, 8'h00, 1'b0, 1'b1, 9'h0C5, 1'b0, 1'b0, 1'b0},
    {7'h30, 2'd2, 1'b0, 8'h00, 1'b1, 1'b0, 9'h130, 1'b0, 1'b0, 1'b0},
    {7'h05, 2'd3, 1'b0, 8'h00, 1'b1, 1'b0, 9'h185, 1'b0, 1'b0, 1'b1},
    {7'h75, 2'd2, 1'b0, 8'h00, 1'b1, 1'b0, 9'h075, 1'b0, 1'b0, 1'b0},
    {7'h7F, 2'd3, 1'b0, 8'h00, 1'b0, 1'b1, 9'h07F, 1'b0, 1'b0, 1'b0},
    {7'h70, 2'd1, 1'b0, 8'h00, 1'b1, 1'b0, 9'h070, 1'b0, 1'b0, 1'b0},
    {7'h00, 2'd3, 1'b0, 8'hA3, 1'b1, 1'b0, 9'h0A3, 1'b0, 1'b0, 1'b0},
    {7'h00, 2'd0, 1'b1, 8'h2C, 1'b1, 1'b0, 9'h12C, 1'b0, 1'b0, 1'b0},
    {7'h00, 2'd1, 1'b1, 8'hF8, 1'b1, 1'b0, 9'h078, 1'b0, 1'b0, 1'b0},
    {7'h00, 2'd0, 1'b0, 8'h00, 1'b1, 1'b0, 9'h000, 1'b1, 1'b0, 1'b1},
    {7'h00, 2'd0, 1'b1, 8'h80, 1'b0, 1'b1, 9'h180, 1'b0, 1'b1, 1'b1},
    {7'h55, 2'd2, 1'b0, 8'h00, 1'b1, 1'b0, 9'h155, 1'b1, 1'b0, 1'b0},
    {7'h40, 2'd3, 1'b0, 8'h00, 1'b0, 1'b1, 9'h1C0, 1'b0, 1'b1, 1'b0},
    {7'h40, 2'd3, 1'b0, 8'h00, 1'b0, 1'b0, 9'h1C0, 1'b0, 1'b0, 1'b0},
    {7'h00, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 9'h000, 1'b0, 1'b0, 1'b1},
    {7'h4F, 2'd2, 1'b0, 8'h00, 1'b1, 1'b0, 9'h14F, 1'b0, 1'b0, 1'b0},
    {7'h50, 2'd2, 1'b0, 8'h00, 1'b1, 1'b1, 9'h150, 1'b1, 1'b1, 1'b0},
    {7'h20, 2'd3, 1'b0, 8'h00, 1'b1, 1'b0, 9'h1A0, 1'b1, 1'b0, 1'b0},
    {7'h1F, 2'd3, 1'b0, 8'h00, 1'b1, 1'b0, 9'h19F, 1'b0, 1'b0, 1'b1},
    {7'h10, 2'd0, 1'b0, 8'h00, 1'b0, 1'b1, 9'h010, 1'b0, 1'b0, 1'b1},
    {7'h00, 2'd2, 1'b1, 8'h55, 1'b1, 1'b0, 9'h155, 1'b1, 1'b0, 1'b0},
    {7'h00, 2'd0, 1'b0, 8'h80, 1'b1, 1'b0, 9'h080, 1'b1, 1'b0, 1'b1}
  };
  localparam string TAG [NV] = '{
    "R1", "R1", "R1", "R4", "R3", "R3", "R3", "R2", "R2", "R3", "R5", "R6",
    "R7", "R7", "R9", "R9", "R7", "R7", "R7", "R4", "R4", "R7", "R5"
  };

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got phys=%h rz=%b wb=%b sfr=%b, want phys=%h rz=%b wb=%b sfr=%b",
               req, act[11:3], act[2], act[1], act[0], exp[11:3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic drive(input logic [6:0] fa, input logic [1:0] bs, input logic ib,
                       input logic [7:0] p, input logic r, input logic w);
    file_addr = fa; bank_sel = bs; ind_bank = ib; ptr = p; rd_en = r; wr_en = w;
  endtask

  function automatic logic [11:0] outs();
    return {phys_addr, rd_zero, wr_block, sfr_sel};
  endfunction

  initial begin
    #3_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: got hang, want completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R8 reset state
    repeat (3) @(negedge clk);
    check("R8", outs(), 12'h000);
    rst = 1'b0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][31:25], VEC[i][24:23], VEC[i][22], VEC[i][21:14],
            VEC[i][13], VEC[i][12]);
      @(negedge clk);
      check(TAG[i], outs(), VEC[i][11:0]);
    end

    // R8 latency: outputs hold previous access until the next rising edge
    @(negedge clk);
    drive(7'h33, 2'd1, 1'b0, 8'h00, 1'b1, 1'b0);
    @(negedge clk);
    check("R8", outs(), {9'h0B3, 3'b000});
    drive(7'h60, 2'd3, 1'b0, 8'h00, 1'b1, 1'b0);
    #5;
    check("R8", outs(), {9'h0B3, 3'b000});
    @(negedge clk);
    check("R7", outs(), {9'h1E0, 3'b100});

    // R1 back-to-back bank changes with the same file address
    for (int b = 0; b < 4; b++) begin
      drive(7'h2A, 2'(b), 1'b0, 8'h00, 1'b0, 1'b0);
      @(negedge clk);
      check("R1", outs(), {2'(b), 7'h2A, 3'b000});
    end

    // R2 bank_sel has no effect on a pointer access
    drive(7'h00, 2'd2, 1'b0, 8'h3B, 1'b1, 1'b0);
    @(negedge clk);
    check("R2", outs(), {9'h03B, 3'b000});

    // R8 reset in mid-run clears outputs
    drive(7'h05, 2'd1, 1'b0, 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    check("R4", outs(), {9'h085, 3'b001});
    rst = 1'b1;
    @(negedge clk);
    check("R8", outs(), 12'h000);
    rst = 1'b0;
    drive(7'h00, 2'd0, 1'b0, 8'h00, 1'b0, 1'b1);
    @(negedge clk);
    check("R6", outs(), {9'h000, 3'b011});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule